// File: doc/BRIEF.md
# Issue Queue Stage Tracker

This block tracks the life of each instruction held in a small out-of-order issue queue. Every occupied slot carries a stage code. A slot starts in waiting while some source operand latency is still unknown. It moves to pending once all latencies are known but operands or memory ordering are not yet satisfied. It becomes ready once every register operand is available and its memory dependency is cleared. A grant from the picker moves it to issued, and a latency down-counter then decides when the slot writes back and frees itself.

The dispatch side offers one instruction per cycle and receives a status code at once. The code says whether the instruction can enter or why it cannot: no free slot, load slots exhausted, store slots exhausted, or a group stall because an instruction of zero latency is ready and has not been issued yet. Refusals for lack of space set a flag that holds until the next tick. Wake-up inputs per slot mark latencies known, operands available or memory dependencies resolved. Per-slot event outputs show which slots entered pending and which entered ready on the last update.

Top module: `iq_tracker`

## Requirements
- R1: A dispatched instruction with any operand latency flag clear enters stage code 00 (waiting) and raises no pending event.
- R2: A waiting slot whose latencies all become known, with operands or memory not yet satisfied, moves to code 01 (pending) and pulses its bit of `pend_evt` for one cycle.
- R3: A slot reaches code 10 (ready) only when its latencies are known, all register operands are available and its memory dependency has been resolved.
- R4: A waiting slot whose remaining conditions are all met in the same update goes straight to ready, and both its `pend_evt` and `rdy_evt` bits pulse in that cycle.
- R5: A grant naming a ready slot moves it to code 11 (issued) and loads its counter with its latency. A grant naming a slot that is not ready has no effect.
- R6: An issued slot's counter decrements on each tick until it reaches zero. The cycle after it is at zero and selected, `wb_valid` pulses with the slot index in `wb_idx`, and the slot is free.
- R7: When several issued slots sit at zero together, the lowest index writes back first and each other slot waits one more cycle per slot ahead of it.
- R8: `disp_status` is 0 available, 1 load slots full, 2 store slots full, 3 no free slot, 4 group stall. The priority is 3, then 1, then 2, then 4. A refused request allocates nothing.
- R9: While a ready slot of zero latency is not being granted in the current cycle, the status is 4 (group stall).
- R10: `stall_seen` sets after a refusal with code 1, 2 or 3, holds while `tick` is low, and clears on a tick cycle that has no such refusal.
- R11: After reset no slot is valid and no output pulses. An accepted instruction takes the lowest free slot, shown on `disp_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_lat_known | input | NSRC | Per-operand latency-known flags |
| disp_opnd_rdy | input | NSRC | Per-operand available flags |
| disp_mem_dep | input | 1 | Instruction waits on a memory dependency |
| disp_is_load | input | 1 | Instruction needs a load slot |
| disp_is_store | input | 1 | Instruction needs a store slot |
| disp_lat | input | LAT_W | Execution latency |
| tick | input | 1 | Time advance for counters and the stall flag |
| issue_valid | input | 1 | Issue grant present |
| issue_idx | input | IW | Slot named by the grant |
| wake_known | input | DEPTH | Per-slot: all latencies now known |
| wake_rdy | input | DEPTH | Per-slot: all operands now available |
| mem_resolve | input | DEPTH | Per-slot: memory dependency resolved |
| disp_status | output | 3 | Dispatch status code |
| disp_idx | output | IW | Slot an accepted dispatch takes |
| valid_vec | output | DEPTH | Occupied slots |
| stage_vec | output | 2*DEPTH | Two-bit stage code per slot |
| ready_vec | output | DEPTH | Slots in the ready stage, for the picker |
| pend_evt | output | DEPTH | Slots that entered pending on the last update |
| rdy_evt | output | DEPTH | Slots that entered ready on the last update |
| wb_valid | output | 1 | Writeback-done pulse |
| wb_idx | output | IW | Slot that wrote back |
| stall_seen | output | 1 | Sticky space-refusal flag |

## Verification
On every cycle, the embedded properties check several rules. A ready slot always has its operands and memory ordering satisfied. A waiting slot never has its latencies known. A grant to a ready slot lands in issued with the right count. A finished slot stays finished until it is picked. A writeback frees its slot and never skips a lower finished slot. Refused requests allocate nothing and raise the flag. Only the bench scenarios can show the exact writeback cycles for overlapping latencies, the ordering between status codes when several limits hit together, the group stall lifting under a grant, and the flag surviving a pause in the tick.

// File: rtl/iq_pkg.sv
package iq_pkg;
    typedef enum logic [1:0] {
        ST_WAIT   = 2'b00,
        ST_PEND   = 2'b01,
        ST_READY  = 2'b10,
        ST_ISSUED = 2'b11
    } stage_e;

    typedef enum logic [2:0] {
        DS_AVAIL    = 3'd0,
        DS_LDQ_FULL = 3'd1,
        DS_STQ_FULL = 3'd2,
        DS_BUF_FULL = 3'd3,
        DS_GROUP    = 3'd4
    } dstat_e;
endpackage

// File: rtl/iq_lowest.sv
module iq_lowest #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/iq_disp_ctl.sv
module iq_disp_ctl
    import iq_pkg::*;
#(
    parameter int N        = 4,
    parameter int LD_SLOTS = 2,
    parameter int ST_SLOTS = 1
) (
    input  logic [N-1:0] valid_vec,
    input  logic [N-1:0] load_vec,
    input  logic [N-1:0] store_vec,
    input  logic [N-1:0] urgent_vec,
    input  logic [N-1:0] grant_vec,
    input  logic         req_load,
    input  logic         req_store,
    output dstat_e       status
);
    logic free_any, ld_full, st_full, grp_hold;

    assign free_any = ~&valid_vec;
    assign ld_full  = req_load  && ($countones(load_vec & valid_vec)  >= LD_SLOTS);
    assign st_full  = req_store && ($countones(store_vec & valid_vec) >= ST_SLOTS);
    assign grp_hold = |(urgent_vec & ~grant_vec);

    always_comb begin
        if (!free_any)    status = DS_BUF_FULL;
        else if (ld_full) status = DS_LDQ_FULL;
        else if (st_full) status = DS_STQ_FULL;
        else if (grp_hold) status = DS_GROUP;
        else              status = DS_AVAIL;
    end
endmodule

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_known,
    input  logic             wr_regs_rdy,
    input  logic             wr_mem_ok,
    input  logic             wr_load,
    input  logic             wr_store,
    input  logic [LAT_W-1:0] wr_lat,
    input  logic             wake_known,
    input  logic             wake_rdy,
    input  logic             mem_resolve,
    input  logic             grant,
    input  logic             tick,
    input  logic             retire,
    output logic             valid_o,
    output stage_e           stage_o,
    output logic             is_load_o,
    output logic             is_store_o,
    output logic             urgent_o,
    output logic             done_o,
    output logic             pend_evt_o,
    output logic             rdy_evt_o
);
    typedef struct packed {
        logic             valid;
        stage_e           stage;
        logic             known;
        logic             regs_rdy;
        logic             mem_ok;
        logic             ld;
        logic             st;
        logic [LAT_W-1:0] lat;
        logic [LAT_W-1:0] cnt;
        logic             pend_evt;
        logic             rdy_evt;
    } ent_t;

    ent_t ent_d, ent_q;
    logic known_n, rdy_n, mem_n;

    assign known_n = ent_q.known    | wake_known;
    assign rdy_n   = ent_q.regs_rdy | wake_rdy;
    assign mem_n   = ent_q.mem_ok   | mem_resolve;

    always_comb begin
        ent_d          = ent_q;
        ent_d.pend_evt = 1'b0;
        ent_d.rdy_evt  = 1'b0;
        if (wr_en) begin
            ent_d.valid    = 1'b1;
            ent_d.known    = wr_known;
            ent_d.regs_rdy = wr_regs_rdy;
            ent_d.mem_ok   = wr_mem_ok;
            ent_d.ld       = wr_load;
            ent_d.st       = wr_store;
            ent_d.lat      = wr_lat;
            ent_d.cnt      = '0;
            if (!wr_known) begin
                ent_d.stage = ST_WAIT;
            end else begin
                ent_d.pend_evt = 1'b1;
                if (wr_regs_rdy && wr_mem_ok) begin
                    ent_d.stage   = ST_READY;
                    ent_d.rdy_evt = 1'b1;
                end else begin
                    ent_d.stage = ST_PEND;
                end
            end
        end else if (ent_q.valid) begin
            ent_d.known    = known_n;
            ent_d.regs_rdy = rdy_n;
            ent_d.mem_ok   = mem_n;
            case (ent_q.stage)
                ST_WAIT: begin
                    if (known_n) begin
                        ent_d.pend_evt = 1'b1;
                        if (rdy_n && mem_n) begin
                            ent_d.stage   = ST_READY;
                            ent_d.rdy_evt = 1'b1;
                        end else begin
                            ent_d.stage = ST_PEND;
                        end
                    end
                end
                ST_PEND: begin
                    if (rdy_n && mem_n) begin
                        ent_d.stage   = ST_READY;
                        ent_d.rdy_evt = 1'b1;
                    end
                end
                ST_READY: begin
                    if (grant) begin
                        ent_d.stage = ST_ISSUED;
                        ent_d.cnt   = ent_q.lat;
                    end
                end
                ST_ISSUED: begin
                    if (retire) begin
                        ent_d = '0;
                    end else if (tick && ent_q.cnt != '0) begin
                        ent_d.cnt = ent_q.cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign valid_o    = ent_q.valid;
    assign stage_o    = ent_q.stage;
    assign is_load_o  = ent_q.ld;
    assign is_store_o = ent_q.st;
    assign urgent_o   = ent_q.valid && ent_q.stage == ST_READY && ent_q.lat == '0;
    assign done_o     = ent_q.valid && ent_q.stage == ST_ISSUED && ent_q.cnt == '0;
    assign pend_evt_o = ent_q.pend_evt;
    assign rdy_evt_o  = ent_q.rdy_evt;

    // R1: a waiting slot never has its latencies known
    p_wait_unknown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ent_q.valid && ent_q.stage == ST_WAIT |-> !ent_q.known);

    // R3: ready implies every condition satisfied
    p_ready_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_q.valid && ent_q.stage == ST_READY |-> ent_q.known && ent_q.regs_rdy && ent_q.mem_ok);

    // R4: a ready event always leaves the slot ready
    p_rdy_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_evt_o |-> valid_o && stage_o == ST_READY);

    // R5: grant on a ready slot lands in issued with its latency loaded
    p_grant_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ent_q.valid && ent_q.stage == ST_READY && grant && !wr_en
        |=> ent_q.valid && ent_q.stage == ST_ISSUED && ent_q.cnt == $past(ent_q.lat));

    // R6: a finished slot stays finished until picked
    p_hold_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !retire |=> done_o);
endmodule

// File: rtl/iq_tracker.sv
module iq_tracker
    import iq_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int NSRC     = 2,
    parameter int LAT_W    = 3,
    parameter int LD_SLOTS = 2,
    parameter int ST_SLOTS = 1,
    localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_valid,
    input  logic [NSRC-1:0]    disp_lat_known,
    input  logic [NSRC-1:0]    disp_opnd_rdy,
    input  logic               disp_mem_dep,
    input  logic               disp_is_load,
    input  logic               disp_is_store,
    input  logic [LAT_W-1:0]   disp_lat,
    input  logic               tick,
    input  logic               issue_valid,
    input  logic [IW-1:0]      issue_idx,
    input  logic [DEPTH-1:0]   wake_known,
    input  logic [DEPTH-1:0]   wake_rdy,
    input  logic [DEPTH-1:0]   mem_resolve,
    output logic [2:0]         disp_status,
    output logic [IW-1:0]      disp_idx,
    output logic [DEPTH-1:0]   valid_vec,
    output logic [2*DEPTH-1:0] stage_vec,
    output logic [DEPTH-1:0]   ready_vec,
    output logic [DEPTH-1:0]   pend_evt,
    output logic [DEPTH-1:0]   rdy_evt,
    output logic               wb_valid,
    output logic [IW-1:0]      wb_idx,
    output logic               stall_seen
);
    typedef struct packed {
        logic          wb_valid;
        logic [IW-1:0] wb_idx;
        logic          sticky;
    } top_t;

    top_t top_d, top_q;

    stage_e           stage_w [DEPTH];
    logic [DEPTH-1:0] load_vec, store_vec, urgent_vec, done_vec, grant_vec;
    logic [DEPTH-1:0] wr_vec, retire_vec;
    logic [IW-1:0]    free_idx, done_idx;
    logic             free_any, done_any, accept, space_refuse;
    dstat_e           stat_w;

    iq_lowest #(.N(DEPTH), .IW(IW)) u_free (
        .req(~valid_vec), .any(free_any), .idx(free_idx));

    iq_lowest #(.N(DEPTH), .IW(IW)) u_done (
        .req(done_vec), .any(done_any), .idx(done_idx));

    iq_disp_ctl #(.N(DEPTH), .LD_SLOTS(LD_SLOTS), .ST_SLOTS(ST_SLOTS)) u_ctl (
        .valid_vec(valid_vec), .load_vec(load_vec), .store_vec(store_vec),
        .urgent_vec(urgent_vec), .grant_vec(grant_vec),
        .req_load(disp_is_load), .req_store(disp_is_store), .status(stat_w));

    assign accept       = disp_valid && stat_w == DS_AVAIL && free_any;
    assign space_refuse = disp_valid && (stat_w == DS_LDQ_FULL || stat_w == DS_STQ_FULL
                                         || stat_w == DS_BUF_FULL);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign grant_vec[i]  = issue_valid && issue_idx == IW'(i);
        assign wr_vec[i]     = accept && free_idx == IW'(i);
        assign retire_vec[i] = done_any && done_idx == IW'(i);

        iq_entry #(.LAT_W(LAT_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_vec[i]),
            .wr_known(&disp_lat_known),
            .wr_regs_rdy(&disp_opnd_rdy),
            .wr_mem_ok(!disp_mem_dep),
            .wr_load(disp_is_load),
            .wr_store(disp_is_store),
            .wr_lat(disp_lat),
            .wake_known(wake_known[i]),
            .wake_rdy(wake_rdy[i]),
            .mem_resolve(mem_resolve[i]),
            .grant(grant_vec[i]),
            .tick(tick),
            .retire(retire_vec[i]),
            .valid_o(valid_vec[i]),
            .stage_o(stage_w[i]),
            .is_load_o(load_vec[i]),
            .is_store_o(store_vec[i]),
            .urgent_o(urgent_vec[i]),
            .done_o(done_vec[i]),
            .pend_evt_o(pend_evt[i]),
            .rdy_evt_o(rdy_evt[i]));

        assign stage_vec[2*i +: 2] = stage_w[i];
        assign ready_vec[i]        = valid_vec[i] && stage_w[i] == ST_READY;
    end

    always_comb begin
        top_d          = top_q;
        top_d.wb_valid = done_any;
        top_d.wb_idx   = done_idx;
        if (tick)         top_d.sticky = 1'b0;
        if (space_refuse) top_d.sticky = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign disp_status = stat_w;
    assign disp_idx    = free_idx;
    assign wb_valid    = top_q.wb_valid;
    assign wb_idx      = top_q.wb_idx;
    assign stall_seen  = top_q.sticky;

    logic [DEPTH-1:0] below_wb;
    assign below_wb = (DEPTH'(1) << wb_idx) - DEPTH'(1);

    // R8: a refused request allocates no slot
    p_refuse_no_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_status != 3'd0 |=> (valid_vec & ~$past(valid_vec)) == '0);

    // R10: a space refusal raises the sticky flag
    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        space_refuse |=> stall_seen);

    // R6: the written-back slot is free
    p_wb_freed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !valid_vec[wb_idx]);

    // R7: no lower finished slot was skipped
    p_wb_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_any |=> wb_valid && ($past(done_vec) & below_wb) == '0);
endmodule

// File: tb/iq_tracker_bench.sv
module iq_tracker_bench;
    localparam int DEPTH = 4;
    localparam int NSRC  = 2;
    localparam int LAT_W = 3;
    localparam int IW    = 2;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               disp_valid;
    logic [NSRC-1:0]    disp_lat_known, disp_opnd_rdy;
    logic               disp_mem_dep, disp_is_load, disp_is_store;
    logic [LAT_W-1:0]   disp_lat;
    logic               tick, issue_valid;
    logic [IW-1:0]      issue_idx;
    logic [DEPTH-1:0]   wake_known, wake_rdy, mem_resolve;
    logic [2:0]         disp_status;
    logic [IW-1:0]      disp_idx, wb_idx;
    logic [DEPTH-1:0]   valid_vec, ready_vec, pend_evt, rdy_evt;
    logic [2*DEPTH-1:0] stage_vec;
    logic               wb_valid, stall_seen;

    iq_tracker u_iq_tracker (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
        .disp_lat_known(disp_lat_known), .disp_opnd_rdy(disp_opnd_rdy),
        .disp_mem_dep(disp_mem_dep), .disp_is_load(disp_is_load),
        .disp_is_store(disp_is_store), .disp_lat(disp_lat), .tick(tick),
        .issue_valid(issue_valid), .issue_idx(issue_idx),
        .wake_known(wake_known), .wake_rdy(wake_rdy), .mem_resolve(mem_resolve),
        .disp_status(disp_status), .disp_idx(disp_idx), .valid_vec(valid_vec),
        .stage_vec(stage_vec), .ready_vec(ready_vec), .pend_evt(pend_evt),
        .rdy_evt(rdy_evt), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .stall_seen(stall_seen));

    always #10 clk = ~clk;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp_idx[$];
    int exp_cyc[$];
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int stg(input int i);
        return int'(stage_vec[2*i +: 2]);
    endfunction

    task automatic step();
        @(negedge clk);
        wake_known  = '0;
        wake_rdy    = '0;
        mem_resolve = '0;
    endtask

    task automatic req(input logic [1:0] kn, input logic [1:0] rd, input logic md,
                       input int lat, input logic ld, input logic st);
        disp_valid     = 1'b1;
        disp_lat_known = kn;
        disp_opnd_rdy  = rd;
        disp_mem_dep   = md;
        disp_lat       = LAT_W'(lat);
        disp_is_load   = ld;
        disp_is_store  = st;
    endtask

    task automatic idle_disp();
        disp_valid = 1'b0; disp_is_load = 1'b0; disp_is_store = 1'b0;
    endtask

    // driver side of the scoreboard: expected writeback slot and cycle
    task automatic expect_wb(input int idx, input int at);
        exp_idx.push_back(idx);
        exp_cyc.push_back(at);
    endtask

    task automatic grant(input int idx);
        issue_valid = 1'b1;
        issue_idx   = IW'(idx);
        step();
        issue_valid = 1'b0;
    endtask

    // monitor side of the scoreboard (R6, R7)
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (exp_idx.size() == 0) begin
                chk("R6 unexpected writeback idx", int'(wb_idx), -1);
            end else begin
                chk("R7 writeback slot", int'(wb_idx), exp_idx.pop_front());
                chk("R6 writeback cycle", cyc, exp_cyc.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int e0;
        rst_n = 1'b0; tick = 1'b1; issue_valid = 1'b0; issue_idx = '0;
        wake_known = '0; wake_rdy = '0; mem_resolve = '0;
        disp_lat_known = '0; disp_opnd_rdy = '0; disp_mem_dep = 1'b0; disp_lat = '0;
        idle_disp();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R11 reset state
        chk("R11 valid after reset", int'(valid_vec), 0);
        chk("R11 ready after reset", int'(ready_vec), 0);
        chk("R11 wb after reset", int'(wb_valid), 0);
        chk("R10 flag after reset", int'(stall_seen), 0);
        chk("R8 idle status", int'(disp_status), 0);

        // A: one latency unknown, lat 0 -> slot 0 waiting
        req(2'b01, 2'b00, 1'b0, 0, 1'b0, 1'b0);
        #1 chk("R11 first slot", int'(disp_idx), 0);
        step(); idle_disp();
        chk("R1 stage slot0", stg(0), 0);
        chk("R1 no pend event", int'(pend_evt), 0);
        chk("R11 valid slot0", int'(valid_vec), 1);

        // B: known, one operand missing, lat 5 -> slot 1 pending
        req(2'b11, 2'b01, 1'b0, 5, 1'b0, 1'b0);
        #1 chk("R11 second slot", int'(disp_idx), 1);
        step(); idle_disp();
        chk("R2 stage slot1", stg(1), 1);
        chk("R2 pend event slot1", int'(pend_evt), 2);

        // C: operands ready, memory dependency, lat 2 -> slot 2 pending
        req(2'b11, 2'b11, 1'b1, 2, 1'b0, 1'b0);
        step(); idle_disp();
        chk("R3 mem dep holds pending", stg(2), 1);

        // A latencies become known, operands still missing
        wake_known[0] = 1'b1;
        step();
        chk("R2 waiting to pending", stg(0), 1);
        chk("R2 pend event slot0", int'(pend_evt), 1);
        chk("R2 no ready event", int'(rdy_evt), 0);

        wake_rdy[1] = 1'b1;
        step();
        chk("R3 operands ready slot1", stg(1), 2);
        chk("R3 ready event slot1", int'(rdy_evt), 2);
        mem_resolve[2] = 1'b1;
        step();
        chk("R3 memory resolved slot2", stg(2), 2);
        chk("R3 ready vector", int'(ready_vec), 6);

        // D: waiting, then everything in one update
        req(2'b10, 2'b11, 1'b0, 1, 1'b0, 1'b0);
        step(); idle_disp();
        chk("R1 slot3 waiting", stg(3), 0);
        wake_known[3] = 1'b1;
        step();
        chk("R4 slot3 ready", stg(3), 2);
        chk("R4 pend event", int'(pend_evt), 8);
        chk("R4 ready event", int'(rdy_evt), 8);

        // full queue, tick paused
        tick = 1'b0;
        req(2'b11, 2'b11, 1'b0, 1, 1'b1, 1'b0);
        #1 chk("R8 buffers full over load", int'(disp_status), 3);
        step(); idle_disp();
        chk("R10 flag set", int'(stall_seen), 1);
        chk("R8 refused no alloc", int'(valid_vec), 15);
        step();
        chk("R10 flag held without tick", int'(stall_seen), 1);
        tick = 1'b1;
        step();
        chk("R10 flag cleared on tick", int'(stall_seen), 0);

        // grant to pending slot is ignored
        grant(0);
        chk("R5 grant to pending ignored", stg(0), 1);

        // overlapping latencies
        grant(1); e0 = cyc;
        chk("R5 slot1 issued", stg(1), 3);
        grant(2);
        grant(3);
        expect_wb(2, e0 + 4);
        expect_wb(3, e0 + 5);
        expect_wb(1, e0 + 6);
        while (cyc < e0 + 7) step();
        chk("R6 slots freed", int'(valid_vec), 1);

        // store slot limit
        req(2'b11, 2'b11, 1'b0, 1, 1'b0, 1'b1);
        step(); idle_disp();
        req(2'b11, 2'b11, 1'b0, 1, 1'b0, 1'b1);
        #1 chk("R8 store slots full", int'(disp_status), 2);
        step(); idle_disp();
        chk("R8 store refused no alloc", int'(valid_vec), 3);

        // two loads fill the queue
        req(2'b00, 2'b00, 1'b0, 1, 1'b1, 1'b0);
        step();
        req(2'b00, 2'b00, 1'b0, 1, 1'b1, 1'b0);
        step(); idle_disp();
        chk("R11 queue full", int'(valid_vec), 15);
        grant(1);
        expect_wb(1, cyc + 2);
        step(); step();
        req(2'b11, 2'b11, 1'b0, 1, 1'b1, 1'b0);
        #1 chk("R8 load slots full", int'(disp_status), 1);
        step(); idle_disp();

        // zero-latency ready slot forces a group stall
        wake_rdy[0] = 1'b1;
        step();
        chk("R3 slot0 ready", stg(0), 2);
        req(2'b00, 2'b00, 1'b0, 1, 1'b0, 1'b0);
        #1 chk("R9 group stall", int'(disp_status), 4);
        issue_valid = 1'b1; issue_idx = 2'd0;
        #1 chk("R9 stall lifted by grant", int'(disp_status), 0);
        step(); issue_valid = 1'b0; idle_disp();
        expect_wb(0, cyc + 1);
        chk("R11 freed slot reused", int'(valid_vec[1]), 1);
        step(); step(); step();
        chk("R6 scoreboard drained", exp_idx.size(), 0);
        finish_run();
    end
endmodule